// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Front End

This block sits between a microcontroller bus and a byte-wide nonvolatile memory array. On that bus, eight lines carry both the low address byte and the data byte. The block captures the address under an address-latch strobe. The low eight bits come from the shared lines and seven upper bits come from dedicated inputs. It then turns the chip enables and the three access strobes into internal requests. Two strobes start a read: a program-fetch strobe and a data-read strobe. Both read the same array, so one device can serve as both code and data memory.

All bus inputs arrive asynchronously and are oversampled by the system clock through a multi-stage synchronizer. The address path passes through a matched delay, so it stays aligned with the synchronized latch strobe. During a read, the block presents a read request and the current address to the array. It then drives the returned byte onto the shared lines through a separate output-enable. A write produces a single-cycle request that carries the address and data to the downstream protection and programming logic. If a read strobe and the write strobe are active together, the access is refused and a sticky error flag is raised.

Top module: `mux_bus_mem_if`

## Requirements
- R1: After reset, ad_oe_o, wr_req_o and proto_err_o are 0 and standby_o is 1.
- R2: While ale_i is high the internal address follows the bus. When ale_i falls, the address is held, and later changes on ad_i and addr_hi_i do not alter it.
- R3: rd_addr_o is the 15-bit address with addr_hi_i in bits 14:8 and ad_i in bits 7:0, both captured at the same latch-strobe fall.
- R4: With the chip enabled, fetch_n_i low and wr_n_i high, ad_oe_o goes to 1 and ad_o carries the array byte at the latched address.
- R5: With the chip enabled, rd_n_i low and wr_n_i high, ad_oe_o goes to 1 and ad_o carries the same array byte that a program-fetch read returns.
- R6: ad_oe_o is 0 whenever neither read strobe is low, including while a write strobe is low.
- R7: The chip is enabled only when ce_n_i is 0 and ce_i is 1. Otherwise standby_o is 1, ad_oe_o stays 0, and no write request is issued.
- R8: On the rising edge of wr_n_i, with the chip enabled, the block issues wr_req_o. The request carries the latched address on wr_addr_o and, on wr_data_o, the ad_i value present at that rising edge.
- R9: Each write strobe yields exactly one wr_req_o pulse, one clock cycle wide.
- R10: If a read strobe and wr_n_i are low together while the chip is enabled, ad_oe_o stays 0 and that write issues no request. proto_err_o becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address-latch strobe, address passes while high |
| ad_i | input | 8 | Shared address/data lines, input side |
| addr_hi_i | input | 7 | Upper address bits |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| fetch_n_i | input | 1 | Active-low program-fetch read strobe |
| rd_n_i | input | 1 | Active-low data read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| ad_o | output | 8 | Shared lines, output side |
| ad_oe_o | output | 1 | Drive enable for the shared lines (1 = drive) |
| standby_o | output | 1 | Chip not selected |
| rd_req_o | output | 1 | Read request to the array |
| rd_addr_o | output | 15 | Current (latched or transparent) address |
| rd_data_i | input | 8 | Byte returned by the array for rd_addr_o |
| wr_req_o | output | 1 | Single-cycle write request |
| wr_addr_o | output | 15 | Write address, valid with wr_req_o |
| wr_data_o | output | 8 | Write data, valid with wr_req_o |
| proto_err_o | output | 1 | Sticky read/write collision flag |

## Verification
The bench scrambles the shared lines after the latch strobe falls. A design that kept the latch transparent would then return the wrong byte or write to the wrong location. During a write, it changes the data while the strobe is low, and it counts request pulses across the whole strobe. This catches a design that samples data at the falling edge or that emits a level instead of a pulse. Each chip enable is dropped on its own. A design that checked only one of them would drive the lines or issue a write while deselected. A collision between a read strobe and the write strobe must leave the lines undriven, issue no write and keep the error flag set through a later clean read. A design that cleared the flag or let the tainted write through is caught there.

// File: rtl/mbi_pkg.sv
`timescale 1ns/1ps
package mbi_pkg;
  localparam int LO_W_DEF = 8;
  localparam int HI_W_DEF = 7;

  // Synchronized control strobes, in the order they are packed.
  typedef struct packed {
    logic cs_n;
    logic cs;
    logic fetch_n;
    logic rd_n;
    logic wr_n;
  } strobes_t;

  // Idle values: deselected, all active-low strobes high.
  localparam strobes_t STROBES_IDLE = '{cs_n: 1'b1, cs: 1'b0, fetch_n: 1'b1,
                                        rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/mbi_sync.sv
`timescale 1ns/1ps
module mbi_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbi_addr_latch.sv
`timescale 1ns/1ps
module mbi_addr_latch #(
  parameter int LO_W   = 8,
  parameter int HI_W   = 7,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic [LO_W-1:0]   lo_s,
  input  logic [HI_W-1:0]   hi_s,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] live;
  logic [ADDR_W-1:0] held_q;
  logic [ADDR_W-1:0] held_d;

  assign live = {hi_s, lo_s};

  always_comb begin
    held_d = held_q;
    if (ale_s) held_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // Transparent while the strobe is high, frozen after it falls.
  assign addr_o = ale_s ? live : held_q;
endmodule

// File: rtl/mbi_decode.sv
`timescale 1ns/1ps
module mbi_decode
  import mbi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  strobes_t st,
  output logic     en,
  output logic     rd_active,
  output logic     wr_accept,
  output logic     conflict
);
  logic rd_any;
  logic wr_rise;
  logic wr_n_d_q, wr_n_d_d;
  logic taint_q, taint_d;

  assign en        = ~st.cs_n & st.cs;
  assign rd_any    = ~st.fetch_n | ~st.rd_n;
  assign rd_active = en & rd_any & st.wr_n;
  assign conflict  = en & rd_any & ~st.wr_n;
  assign wr_rise   = st.wr_n & ~wr_n_d_q;
  assign wr_accept = wr_rise & en & ~rd_any & ~taint_q;

  always_comb begin
    wr_n_d_d = st.wr_n;
    taint_d  = taint_q;
    if (wr_rise)       taint_d = 1'b0;
    else if (conflict) taint_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_d_q <= 1'b1;
      taint_q  <= 1'b0;
    end else begin
      wr_n_d_q <= wr_n_d_d;
      taint_q  <= taint_d;
    end
  end

  // R10: a collision seen in one cycle blocks a write accept in the next.
  p_collision_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> !wr_accept);
endmodule

// File: rtl/mux_bus_mem_if.sv
`timescale 1ns/1ps
module mux_bus_mem_if
  import mbi_pkg::*;
#(
  parameter int LO_W        = LO_W_DEF,
  parameter int HI_W        = HI_W_DEF,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              ce_n_i,
  input  logic              ce_i,
  input  logic              fetch_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  output logic [LO_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic              standby_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [LO_W-1:0]   rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LO_W-1:0]   wr_data_o,
  output logic              proto_err_o
);
  localparam int AP_W = ADDR_W + 1;
  localparam int ST_W = $bits(strobes_t);

  // Address path: strobe and bus delayed together so they stay aligned.
  logic [AP_W-1:0] ap_s;
  logic            ale_s;
  logic [HI_W-1:0] hi_s;
  logic [LO_W-1:0] lo_s;

  mbi_sync #(.W(AP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ap_sync (
    .clk(clk), .rst_n(rst_n), .d({ale_i, addr_hi_i, ad_i}), .q(ap_s));

  assign ale_s = ap_s[AP_W-1];
  assign hi_s  = ap_s[ADDR_W-1:LO_W];
  assign lo_s  = ap_s[LO_W-1:0];

  logic [ST_W-1:0] st_raw_s;
  strobes_t        st_s;

  mbi_sync #(.W(ST_W), .STAGES(SYNC_STAGES), .RST_VAL(STROBES_IDLE)) u_st_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n_i, ce_i, fetch_n_i, rd_n_i, wr_n_i}), .q(st_raw_s));

  assign st_s = strobes_t'(st_raw_s);

  logic [ADDR_W-1:0] addr_cur;

  mbi_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .lo_s(lo_s), .hi_s(hi_s),
    .addr_o(addr_cur));

  logic en, rd_active, wr_accept, conflict;

  mbi_decode u_dec (
    .clk(clk), .rst_n(rst_n), .st(st_s), .en(en), .rd_active(rd_active),
    .wr_accept(wr_accept), .conflict(conflict));

  // Output registers.
  logic              oe_q, oe_d;
  logic [LO_W-1:0]   dout_q, dout_d;
  logic              wreq_q, wreq_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [LO_W-1:0]   wdata_q, wdata_d;
  logic              err_q, err_d;

  always_comb begin
    oe_d    = rd_active;
    dout_d  = dout_q;
    wreq_d  = wr_accept;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    err_d   = err_q | conflict;
    if (rd_active) dout_d = rd_data_i;
    if (wr_accept) begin
      waddr_d = addr_cur;
      wdata_d = lo_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      dout_q  <= '0;
      wreq_q  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      oe_q    <= oe_d;
      dout_q  <= dout_d;
      wreq_q  <= wreq_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      err_q   <= err_d;
    end
  end

  assign ad_o        = dout_q;
  assign ad_oe_o     = oe_q;
  assign standby_o   = ~en;
  assign rd_req_o    = rd_active;
  assign rd_addr_o   = addr_cur;
  assign wr_req_o    = wreq_q;
  assign wr_addr_o   = waddr_q;
  assign wr_data_o   = wdata_q;
  assign proto_err_o = err_q;

  // R9: a write request never lasts two cycles.
  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o);

  // R10: the collision flag never clears on its own.
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  // R8: the write address is the one presented in the accepting cycle.
  p_wr_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> (wr_addr_o == $past(rd_addr_o)));

  // R7: deselected for two cycles means the lines are not driven.
  p_standby_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_o && $past(standby_o)) |-> !ad_oe_o);

  // R10: driving the lines and a write request never coincide.
  p_oe_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe_o && wr_req_o));
endmodule

// File: tb/tb_mux_bus_mem_if.sv
`timescale 1ns/1ps
module tb_mux_bus_mem_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ale_i;
  logic [7:0]  ad_i;
  logic [6:0]  addr_hi_i;
  logic        ce_n_i, ce_i, fetch_n_i, rd_n_i, wr_n_i;
  logic [7:0]  ad_o;
  logic        ad_oe_o, standby_o, rd_req_o;
  logic [14:0] rd_addr_o;
  logic [7:0]  rd_data_i;
  logic        wr_req_o;
  logic [14:0] wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        proto_err_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h3C;
  endfunction

  assign rd_data_i = mem_f(rd_addr_o);

  mux_bus_mem_if dut (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i), .addr_hi_i(addr_hi_i),
    .ce_n_i(ce_n_i), .ce_i(ce_i), .fetch_n_i(fetch_n_i), .rd_n_i(rd_n_i),
    .wr_n_i(wr_n_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .standby_o(standby_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .proto_err_o(proto_err_o));

  // Window monitor sampled away from the active edge.
  logic        mon_on = 1'b0;
  int          wr_cnt, oe_cnt;
  logic [14:0] cap_addr;
  logic [7:0]  cap_data;

  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_req_o) begin
        wr_cnt++;
        cap_addr = wr_addr_o;
        cap_data = wr_data_o;
      end
      if (ad_oe_o) oe_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_start();
    wr_cnt = 0; oe_cnt = 0; mon_on = 1'b1;
  endtask

  task automatic set_addr(input logic [6:0] hi, input logic [7:0] lo);
    ale_i = 1'b1; addr_hi_i = hi; ad_i = lo;
    cyc(4);
    ale_i = 1'b0;
    cyc(4);
    ad_i = ~lo; addr_hi_i = ~hi;   // scramble after the latch closes
    cyc(4);
  endtask

  task automatic t_reset();
    chk(ad_oe_o == 1'b0,     "R1 oe", ad_oe_o, 0);
    chk(wr_req_o == 1'b0,    "R1 wr_req", wr_req_o, 0);
    chk(proto_err_o == 1'b0, "R1 err", proto_err_o, 0);
    chk(standby_o == 1'b1,   "R1 standby", standby_o, 1);
  endtask

  task automatic t_read(input logic [6:0] hi, input logic [7:0] lo, input bit use_fetch,
                        input string tag);
    logic [14:0] a;
    a = {hi, lo};
    set_addr(hi, lo);
    chk(rd_addr_o == a, "R2 R3 latched address", rd_addr_o, a);
    if (use_fetch) fetch_n_i = 1'b0; else rd_n_i = 1'b0;
    cyc(6);
    chk(ad_oe_o == 1'b1, {tag, " oe"}, ad_oe_o, 1);
    chk(ad_o == mem_f(a), {tag, " data"}, ad_o, mem_f(a));
    fetch_n_i = 1'b1; rd_n_i = 1'b1;
    cyc(6);
    chk(ad_oe_o == 1'b0, "R6 oe released", ad_oe_o, 0);
  endtask

  task automatic t_write(input logic [6:0] hi, input logic [7:0] lo,
                         input logic [7:0] d0, input logic [7:0] d1);
    set_addr(hi, lo);
    mon_start();
    ad_i = d0; wr_n_i = 1'b0;
    cyc(3);
    ad_i = d1;
    cyc(4);
    wr_n_i = 1'b1;
    cyc(8);
    mon_on = 1'b0;
    chk(wr_cnt == 1, "R8 R9 one write pulse", wr_cnt, 1);
    chk(cap_addr == {hi, lo}, "R8 write address", cap_addr, {hi, lo});
    chk(cap_data == d1, "R8 write data at rising edge", cap_data, d1);
    chk(oe_cnt == 0, "R6 no drive during write", oe_cnt, 0);
  endtask

  task automatic t_disabled(input bit drop_low_en);
    string tag;
    tag = drop_low_en ? "R7 ce_n high" : "R7 ce low";
    set_addr(7'h11, 8'h22);
    if (drop_low_en) ce_n_i = 1'b1; else ce_i = 1'b0;
    cyc(4);
    mon_start();
    rd_n_i = 1'b0; cyc(6); rd_n_i = 1'b1; cyc(2);
    fetch_n_i = 1'b0; cyc(6); fetch_n_i = 1'b1; cyc(2);
    ad_i = 8'h99; wr_n_i = 1'b0; cyc(6); wr_n_i = 1'b1; cyc(6);
    mon_on = 1'b0;
    chk(standby_o == 1'b1, {tag, " standby"}, standby_o, 1);
    chk(oe_cnt == 0, {tag, " no drive"}, oe_cnt, 0);
    chk(wr_cnt == 0, {tag, " no write"}, wr_cnt, 0);
    ce_n_i = 1'b0; ce_i = 1'b1;
    cyc(4);
    chk(standby_o == 1'b0, "R7 enabled again", standby_o, 0);
  endtask

  task automatic t_conflict();
    chk(proto_err_o == 1'b0, "R10 err clear before collision", proto_err_o, 0);
    set_addr(7'h2A, 8'h55);
    mon_start();
    ad_i = 8'hA5;
    rd_n_i = 1'b0; wr_n_i = 1'b0;
    cyc(6);
    rd_n_i = 1'b1; wr_n_i = 1'b1;
    cyc(8);
    mon_on = 1'b0;
    chk(oe_cnt == 0, "R10 no drive on collision", oe_cnt, 0);
    chk(wr_cnt == 0, "R10 no write on collision", wr_cnt, 0);
    chk(proto_err_o == 1'b1, "R10 err set", proto_err_o, 1);
    t_read(7'h05, 8'h06, 1'b0, "R5 read after collision");
    chk(proto_err_o == 1'b1, "R10 err sticky", proto_err_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ale_i = 1'b0; ad_i = '0; addr_hi_i = '0;
    ce_n_i = 1'b1; ce_i = 1'b0; fetch_n_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    ce_n_i = 1'b0; ce_i = 1'b1;
    cyc(4);
    t_read(7'h7F, 8'h00, 1'b1, "R4 fetch read");
    t_read(7'h7F, 8'h00, 1'b0, "R5 data read same byte");
    t_read(7'h00, 8'hFF, 1'b1, "R4 fetch read low page");
    t_read(7'h35, 8'hC3, 1'b0, "R5 data read");
    t_write(7'h12, 8'h34, 8'h0F, 8'hE1);
    t_write(7'h7F, 8'hFF, 8'h00, 8'h5A);
    t_disabled(1'b1);
    t_disabled(1'b0);
    t_conflict();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule